// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor-side request port and a cache controller and keeps a record of every cache-line request still in flight. Each request names a kind, a byte address and a length. The block either accepts the request or rejects it. It answers in the same cycle with a status and, on acceptance, with a fresh request ID. Accepted requests go into one of two small fully associative tables keyed by line address. Write-class requests go to one table and read-class requests to the other. Each entry holds the line tag, the ID and the cycle stamp at which it was accepted.

When the cache controller finishes a line, it presents a completion that names the line and the table. The matching entry is removed, and the block returns the entry's ID and its latency in cycles. A completion that finds no matching entry sets a sticky error. A request to a line that either table already holds is refused. Each such refusal is counted in one of four counters, chosen by the class of the entry that blocks it and the flavour of the new request.

A watchdog scans both tables once every `age_limit` cycles while anything is outstanding. It raises a sticky hang flag if any entry has been outstanding for at least that long.

Top module: `req_tracker`

## Requirements
- R1: Kinds store (2), read-modify-write read (3), read-modify-write write (4), locked read (5) and locked write (6) are recorded in the write table. Load (0) and instruction fetch (1) are recorded in the read table. A completion finds an entry only when `cpl_wr` names that entry's table (1 = write table).
- R2: A request whose line address (address bits above the low `OFFS_W` bits) is held in either table gets status 1 (aliased), and no entry is added.
- R3: When `outstanding` is at or above `MAX_OUT`, or the target table has no free slot, a request gets status 2 (full), and no entry is added.
- R4: A request of kind 7, or one whose byte offset within the line plus `req_len` exceeds 2^`OFFS_W`, gets status 3 (malformed). An offset plus length exactly equal to the line size is accepted.
- R5: Status priority is malformed, then aliased, then full. Status 0 (accepted) is given only when none of the three applies.
- R6: `req_id` shown with an accepted request equals the number of requests accepted since reset, starting at 0. Rejected requests do not consume an ID.
- R7: A completion that hits reports `cpl_hit`=1, the stored ID on `cpl_id`, and on `cpl_latency` the completion cycle minus the acceptance cycle. It removes the entry, so the line can be requested again. `cpl_lat_valid` is 1 only when the completion hits and the latency is nonzero.
- R8: A completion that misses gives `cpl_hit`=0 and sets `err_miss` from the next cycle until reset. It leaves `outstanding` unchanged.
- R9: `outstanding` equals the number of accepted requests minus the number of completions that hit, and it always equals the sum of the two tables' occupancies.
- R10: Each aliased rejection increments exactly one wait counter. The counter is chosen by the blocking table (write or read) and by the new request's flavour. Kinds 0, 1, 3 and 5 count as read-flavoured; the other kinds count as write-flavoured. No counter changes on any other cycle.
- R11: The watchdog starts a period when a request is accepted while it is disarmed. It checks entry ages at the end of each `age_limit`-cycle period. If the arming entry is still present, `hang` is 1 from `age_limit`+1 cycles after that entry was accepted. An entry completed before the check raises nothing, and `hang` stays set until reset.
- R12: The watchdog disarms as soon as `outstanding` returns to zero. The next accepted request starts a fresh period rather than continuing the old one.
- R13: Reset clears both tables, `outstanding`, the ID counter, all wait counters, `err_miss` and `hang`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| age_limit | input | TS_W | Watchdog period and age threshold in cycles (at least 1) |
| req_valid | input | 1 | New request present this cycle |
| req_kind | input | 3 | Request kind code (0..6 defined, 7 malformed) |
| req_addr | input | ADDR_W | Byte address of the request |
| req_len | input | OFFS_W+1 | Byte length of the request |
| req_status | output | 2 | 0 accepted, 1 aliased, 2 full, 3 malformed |
| req_id | output | ID_W | ID assigned if the request is accepted |
| cpl_valid | input | 1 | Completion present this cycle |
| cpl_wr | input | 1 | Completion targets the write table (1) or the read table (0) |
| cpl_line | input | ADDR_W-OFFS_W | Line address being completed |
| cpl_hit | output | 1 | Completion matched an entry |
| cpl_id | output | ID_W | ID of the matched entry |
| cpl_latency | output | TS_W | Cycles from acceptance to completion |
| cpl_lat_valid | output | 1 | Hit with a nonzero latency |
| err_miss | output | 1 | Sticky: a completion found no entry |
| hang | output | 1 | Sticky: the watchdog found an over-age entry |
| outstanding | output | OUT_W | Entries held across both tables |
| wait_rd_on_rd | output | CNT_W | Read-flavoured requests refused by a read-table entry |
| wait_wr_on_rd | output | CNT_W | Write-flavoured requests refused by a read-table entry |
| wait_rd_on_wr | output | CNT_W | Read-flavoured requests refused by a write-table entry |
| wait_wr_on_wr | output | CNT_W | Write-flavoured requests refused by a write-table entry |

## Verification
The checker assumes that `age_limit` is never zero and stays well below 2^`TS_W`, so that age arithmetic cannot wrap. It also assumes that the controller completes each line at most once. The bench holds `age_limit` at 1000 during functional traffic and at 10 during the watchdog tests, and it changes the value only while the tracker is idle. It deliberately sends one completion to a line that is no longer held, to provoke the miss error. The bench never lets an entry live long enough for a timestamp to wrap.

// File: rtl/rqt_pkg.sv
package rqt_pkg;

    typedef enum logic [2:0] {
        K_LOAD   = 3'd0,
        K_IFETCH = 3'd1,
        K_STORE  = 3'd2,
        K_RMW_RD = 3'd3,
        K_RMW_WR = 3'd4,
        K_LK_RD  = 3'd5,
        K_LK_WR  = 3'd6,
        K_UNDEF  = 3'd7
    } kind_e;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_ALIAS = 2'd1,
        ST_FULL  = 2'd2,
        ST_BAD   = 2'd3
    } status_e;

    // wait counter index = {blocked_by_write_table, new_is_read_flavoured}
    localparam int NUM_WAIT = 4;
    localparam logic [1:0] W_WR_ON_RD = 2'd0;
    localparam logic [1:0] W_RD_ON_RD = 2'd1;
    localparam logic [1:0] W_WR_ON_WR = 2'd2;
    localparam logic [1:0] W_RD_ON_WR = 2'd3;

    function automatic logic goes_to_write_table(kind_e k);
        return (k == K_STORE) || (k == K_RMW_RD) || (k == K_RMW_WR) ||
               (k == K_LK_RD) || (k == K_LK_WR);
    endfunction

    function automatic logic is_read_flavoured(kind_e k);
        return (k == K_LOAD) || (k == K_IFETCH) || (k == K_RMW_RD) || (k == K_LK_RD);
    endfunction

endpackage

// File: rtl/rqt_table.sv
module rqt_table #(
    parameter int ENTRIES = 8,
    parameter int LINE_W  = 26,
    parameter int ID_W    = 12,
    parameter int TS_W    = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [TS_W-1:0]               now,
    input  logic [TS_W-1:0]               age_limit,
    input  logic                          ins_en,
    input  logic [LINE_W-1:0]             ins_tag,
    input  logic [ID_W-1:0]               ins_id,
    input  logic [LINE_W-1:0]             lk_tag,
    output logic                          lk_hit,
    input  logic                          cpl_en,
    input  logic [LINE_W-1:0]             cpl_tag,
    output logic                          cpl_hit,
    output logic [ID_W-1:0]               cpl_id,
    output logic [TS_W-1:0]               cpl_ts,
    output logic                          full,
    output logic [$clog2(ENTRIES+1)-1:0]  occ,
    output logic                          stale
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int OCC_W = $clog2(ENTRIES + 1);

    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] tag;
        logic [ID_W-1:0]   id;
        logic [TS_W-1:0]   ts;
    } slot_t;

    slot_t              slots [ENTRIES];
    logic [ENTRIES-1:0] vld_v;
    logic [ENTRIES-1:0] lk_m;
    logic [ENTRIES-1:0] cp_m;
    logic [ENTRIES-1:0] old_m;
    logic [IDX_W-1:0]   ins_idx;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic [TS_W-1:0] age;
        assign age      = now - slots[i].ts;
        assign vld_v[i] = slots[i].vld;
        assign lk_m[i]  = slots[i].vld && (slots[i].tag == lk_tag);
        assign cp_m[i]  = slots[i].vld && (slots[i].tag == cpl_tag);
        assign old_m[i] = slots[i].vld && (age >= age_limit);

        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i] <= '0;
            end else if (ins_en && (ins_idx == IDX_W'(i))) begin
                slots[i] <= '{vld: 1'b1, tag: ins_tag, id: ins_id, ts: now};
            end else if (cpl_en && cp_m[i]) begin
                slots[i].vld <= 1'b0;
            end
        end
    end

    // lowest free slot wins
    always_comb begin
        ins_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_v[i]) ins_idx = IDX_W'(i);
        end
    end

    // at most one slot matches a tag, so an OR merge is enough
    always_comb begin
        cpl_id = '0;
        cpl_ts = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (cp_m[i]) begin
                cpl_id = cpl_id | slots[i].id;
                cpl_ts = cpl_ts | slots[i].ts;
            end
        end
    end

    assign lk_hit  = |lk_m;
    assign cpl_hit = |cp_m;
    assign full    = &vld_v;
    assign stale   = |old_m;
    assign occ     = OCC_W'($countones(vld_v));

endmodule

// File: rtl/rqt_watchdog.sv
module rqt_watchdog #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TS_W-1:0] age_limit,
    input  logic            accept,
    input  logic            going_idle,
    input  logic            stale_any,
    output logic            armed,
    output logic            hang
);
    logic [TS_W-1:0] wd_cnt;
    logic            scan;

    assign scan = armed && (wd_cnt == age_limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            wd_cnt <= '0;
        end else if (going_idle) begin
            armed  <= 1'b0;
            wd_cnt <= '0;
        end else if (!armed && accept) begin
            armed  <= 1'b1;
            wd_cnt <= '0;
        end else if (armed) begin
            wd_cnt <= scan ? '0 : wd_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    hang <= 1'b0;
        else if (scan && stale_any) hang <= 1'b1;
    end

endmodule

// File: rtl/rqt_wait_ctr.sv
module rqt_wait_ctr
    import rqt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              bump,
    input  logic [1:0]                        sel,
    output logic [NUM_WAIT-1:0][CNT_W-1:0]    cnt
);
    for (genvar i = 0; i < NUM_WAIT; i++) begin : g_ctr
        always_ff @(posedge clk) begin
            if (rst)                             cnt[i] <= '0;
            else if (bump && (sel == 2'(i)))     cnt[i] <= cnt[i] + 1'b1;
        end
    end
endmodule

// File: rtl/req_tracker.sv
module req_tracker
    import rqt_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OFFS_W  = 6,
    parameter int ENTRIES = 8,
    parameter int MAX_OUT = 6,
    parameter int ID_W    = 12,
    parameter int TS_W    = 16,
    parameter int CNT_W   = 16,
    localparam int LINE_W = ADDR_W - OFFS_W,
    localparam int OCC_W  = $clog2(ENTRIES + 1),
    localparam int OUT_W  = $clog2(2 * ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TS_W-1:0]   age_limit,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [OFFS_W:0]   req_len,
    output logic [1:0]        req_status,
    output logic [ID_W-1:0]   req_id,
    input  logic              cpl_valid,
    input  logic              cpl_wr,
    input  logic [LINE_W-1:0] cpl_line,
    output logic              cpl_hit,
    output logic [ID_W-1:0]   cpl_id,
    output logic [TS_W-1:0]   cpl_latency,
    output logic              cpl_lat_valid,
    output logic              err_miss,
    output logic              hang,
    output logic [OUT_W-1:0]  outstanding,
    output logic [CNT_W-1:0]  wait_rd_on_rd,
    output logic [CNT_W-1:0]  wait_wr_on_rd,
    output logic [CNT_W-1:0]  wait_rd_on_wr,
    output logic [CNT_W-1:0]  wait_wr_on_wr
);
    localparam logic [OFFS_W+1:0] LINE_BYTES = (OFFS_W + 2)'(2 ** OFFS_W);

    kind_e              kind;
    logic [LINE_W-1:0]  line;
    logic [OFFS_W+1:0]  span;
    logic               to_wr;
    logic               malformed;
    logic               alias_any;
    logic               no_room;
    status_e            status;
    logic               accept;

    logic [TS_W-1:0]    now;
    logic [ID_W-1:0]    next_id;
    logic [OUT_W-1:0]   count;
    logic [OUT_W-1:0]   count_next;

    logic               lk_hit_wr, lk_hit_rd;
    logic               cp_hit_wr, cp_hit_rd;
    logic [ID_W-1:0]    cp_id_wr, cp_id_rd;
    logic [TS_W-1:0]    cp_ts_wr, cp_ts_rd;
    logic               full_wr, full_rd;
    logic [OCC_W-1:0]   occ_wr, occ_rd;
    logic               stale_wr, stale_rd;
    logic               hit_sel;
    logic [TS_W-1:0]    ts_sel;
    logic               wd_armed;
    logic               bump_wait;
    logic [1:0]         wait_sel;
    logic [NUM_WAIT-1:0][CNT_W-1:0] wait_cnt;

    // ---------------- request classification ----------------
    assign kind      = kind_e'(req_kind);
    assign line      = req_addr[ADDR_W-1:OFFS_W];
    assign span      = {2'b00, req_addr[OFFS_W-1:0]} + {1'b0, req_len};
    assign to_wr     = goes_to_write_table(kind);
    assign malformed = (kind == K_UNDEF) || (span > LINE_BYTES);
    assign alias_any = lk_hit_wr || lk_hit_rd;
    assign no_room   = (count >= OUT_W'(MAX_OUT)) || (to_wr ? full_wr : full_rd);

    always_comb begin
        if (malformed)      status = ST_BAD;
        else if (alias_any) status = ST_ALIAS;
        else if (no_room)   status = ST_FULL;
        else                status = ST_OK;
    end

    assign accept     = req_valid && (status == ST_OK);
    assign req_status = status;
    assign req_id     = next_id;

    // ---------------- tables ----------------
    rqt_table #(
        .ENTRIES(ENTRIES), .LINE_W(LINE_W), .ID_W(ID_W), .TS_W(TS_W)
    ) u_wr_tbl (
        .clk(clk), .rst(rst), .now(now), .age_limit(age_limit),
        .ins_en(accept && to_wr), .ins_tag(line), .ins_id(next_id),
        .lk_tag(line), .lk_hit(lk_hit_wr),
        .cpl_en(cpl_valid && cpl_wr), .cpl_tag(cpl_line),
        .cpl_hit(cp_hit_wr), .cpl_id(cp_id_wr), .cpl_ts(cp_ts_wr),
        .full(full_wr), .occ(occ_wr), .stale(stale_wr)
    );

    rqt_table #(
        .ENTRIES(ENTRIES), .LINE_W(LINE_W), .ID_W(ID_W), .TS_W(TS_W)
    ) u_rd_tbl (
        .clk(clk), .rst(rst), .now(now), .age_limit(age_limit),
        .ins_en(accept && !to_wr), .ins_tag(line), .ins_id(next_id),
        .lk_tag(line), .lk_hit(lk_hit_rd),
        .cpl_en(cpl_valid && !cpl_wr), .cpl_tag(cpl_line),
        .cpl_hit(cp_hit_rd), .cpl_id(cp_id_rd), .cpl_ts(cp_ts_rd),
        .full(full_rd), .occ(occ_rd), .stale(stale_rd)
    );

    // ---------------- completion path ----------------
    assign hit_sel       = cpl_valid && (cpl_wr ? cp_hit_wr : cp_hit_rd);
    assign ts_sel        = cpl_wr ? cp_ts_wr : cp_ts_rd;
    assign cpl_hit       = hit_sel;
    assign cpl_id        = hit_sel ? (cpl_wr ? cp_id_wr : cp_id_rd) : '0;
    assign cpl_latency   = hit_sel ? (now - ts_sel) : '0;
    assign cpl_lat_valid = hit_sel && (cpl_latency != '0);

    always_ff @(posedge clk) begin
        if (rst)                       err_miss <= 1'b0;
        else if (cpl_valid && !hit_sel) err_miss <= 1'b1;
    end

    // ---------------- time, IDs, occupancy ----------------
    assign count_next = count + OUT_W'(accept) - OUT_W'(hit_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            now     <= '0;
            next_id <= '0;
            count   <= '0;
        end else begin
            now     <= now + 1'b1;
            count   <= count_next;
            if (accept) next_id <= next_id + 1'b1;
        end
    end

    assign outstanding = count;

    // ---------------- watchdog ----------------
    rqt_watchdog #(.TS_W(TS_W)) u_wd (
        .clk(clk), .rst(rst), .age_limit(age_limit),
        .accept(accept), .going_idle(count_next == '0),
        .stale_any(stale_wr || stale_rd),
        .armed(wd_armed), .hang(hang)
    );

    // ---------------- alias wait counters ----------------
    assign bump_wait = req_valid && (status == ST_ALIAS);
    assign wait_sel  = {lk_hit_wr, is_read_flavoured(kind)};

    rqt_wait_ctr #(.CNT_W(CNT_W)) u_wait (
        .clk(clk), .rst(rst), .bump(bump_wait), .sel(wait_sel), .cnt(wait_cnt)
    );

    assign wait_wr_on_rd = wait_cnt[W_WR_ON_RD];
    assign wait_rd_on_rd = wait_cnt[W_RD_ON_RD];
    assign wait_wr_on_wr = wait_cnt[W_WR_ON_WR];
    assign wait_rd_on_wr = wait_cnt[W_RD_ON_WR];

endmodule

// File: rtl/rqt_checker.sv
module rqt_checker
    import rqt_pkg::*;
#(
    parameter int MAX_OUT = 6,
    parameter int ID_W    = 12,
    parameter int TS_W    = 16,
    parameter int CNT_W   = 16,
    parameter int OCC_W   = 4,
    parameter int OUT_W   = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [TS_W-1:0]  age_limit,
    input logic             req_valid,
    input logic [1:0]       req_status,
    input logic [ID_W-1:0]  req_id,
    input logic             cpl_valid,
    input logic             cpl_hit,
    input logic [TS_W-1:0]  cpl_latency,
    input logic             cpl_lat_valid,
    input logic             err_miss,
    input logic             hang,
    input logic [OUT_W-1:0] outstanding,
    input logic [OCC_W-1:0] occ_wr,
    input logic [OCC_W-1:0] occ_rd,
    input logic             wd_armed,
    input logic [CNT_W-1:0] wait_rd_on_rd,
    input logic [CNT_W-1:0] wait_wr_on_rd,
    input logic [CNT_W-1:0] wait_rd_on_wr,
    input logic [CNT_W-1:0] wait_wr_on_wr
);
    // input assumption: the watchdog period is never zero
    age_limit_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        age_limit != '0);

    // R9
    count_match_chk: assert property (@(posedge clk) disable iff (rst)
        {1'b0, outstanding} == ({1'b0, occ_wr} + {1'b0, occ_rd}));

    // R3
    accept_below_max_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_status == 2'd0) |-> (outstanding < OUT_W'(MAX_OUT)));

    // R2
    alias_no_insert_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_status == 2'd1 && !cpl_valid) |=> (outstanding == $past(outstanding)));

    // R6
    id_step_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_status == 2'd0) |=> (req_id == $past(req_id) + 1'b1));

    // R6
    id_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_status == 2'd0) |=> $stable(req_id));

    // R7
    lat_valid_chk: assert property (@(posedge clk) disable iff (rst)
        cpl_lat_valid |-> (cpl_hit && cpl_latency != '0));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_miss |=> err_miss);

    // R8
    miss_sets_err_chk: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && !cpl_hit) |=> err_miss);

    // R11
    hang_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        hang |=> hang);

    // R12
    idle_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        (outstanding == '0) |-> !wd_armed);

    // R10
    wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_status == 2'd1) |=>
            ($stable(wait_rd_on_rd) && $stable(wait_wr_on_rd) &&
             $stable(wait_rd_on_wr) && $stable(wait_wr_on_wr)));
endmodule

bind req_tracker rqt_checker #(
    .MAX_OUT(MAX_OUT), .ID_W(ID_W), .TS_W(TS_W), .CNT_W(CNT_W),
    .OCC_W(OCC_W), .OUT_W(OUT_W)
) u_chk (
    .clk(clk), .rst(rst), .age_limit(age_limit),
    .req_valid(req_valid), .req_status(req_status), .req_id(req_id),
    .cpl_valid(cpl_valid), .cpl_hit(cpl_hit), .cpl_latency(cpl_latency),
    .cpl_lat_valid(cpl_lat_valid), .err_miss(err_miss), .hang(hang),
    .outstanding(outstanding), .occ_wr(occ_wr), .occ_rd(occ_rd),
    .wd_armed(wd_armed),
    .wait_rd_on_rd(wait_rd_on_rd), .wait_wr_on_rd(wait_wr_on_rd),
    .wait_rd_on_wr(wait_rd_on_wr), .wait_wr_on_wr(wait_wr_on_wr)
);

// File: tb/tb_req_tracker.sv
module tb_req_tracker;
    localparam int ADDR_W = 32;
    localparam int OFFS_W = 6;
    localparam int LINE_W = ADDR_W - OFFS_W;
    localparam int ID_W   = 12;
    localparam int TS_W   = 16;
    localparam int CNT_W  = 16;
    localparam int OUT_W  = 5;
    localparam int NVEC   = 15;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [TS_W-1:0]   age_limit = 16'd1000;
    logic              req_valid = 1'b0;
    logic [2:0]        req_kind = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [OFFS_W:0]   req_len = '0;
    logic [1:0]        req_status;
    logic [ID_W-1:0]   req_id;
    logic              cpl_valid = 1'b0;
    logic              cpl_wr = 1'b0;
    logic [LINE_W-1:0] cpl_line = '0;
    logic              cpl_hit;
    logic [ID_W-1:0]   cpl_id;
    logic [TS_W-1:0]   cpl_latency;
    logic              cpl_lat_valid;
    logic              err_miss;
    logic              hang;
    logic [OUT_W-1:0]  outstanding;
    logic [CNT_W-1:0]  wait_rd_on_rd, wait_wr_on_rd, wait_rd_on_wr, wait_wr_on_wr;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    req_tracker dut (
        .clk(clk), .rst(rst), .age_limit(age_limit),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr), .req_len(req_len),
        .req_status(req_status), .req_id(req_id),
        .cpl_valid(cpl_valid), .cpl_wr(cpl_wr), .cpl_line(cpl_line),
        .cpl_hit(cpl_hit), .cpl_id(cpl_id), .cpl_latency(cpl_latency),
        .cpl_lat_valid(cpl_lat_valid), .err_miss(err_miss), .hang(hang),
        .outstanding(outstanding),
        .wait_rd_on_rd(wait_rd_on_rd), .wait_wr_on_rd(wait_wr_on_rd),
        .wait_rd_on_wr(wait_rd_on_wr), .wait_wr_on_wr(wait_wr_on_wr)
    );

    typedef struct packed {
        logic [2:0]  k;
        logic [31:0] a;
        logic [6:0]  l;
        logic [1:0]  s;
        logic [11:0] i;
    } vec_t;

    // kind, address, length, expected status, expected id (when accepted)
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 32'h0000_1000, 7'd8,  2'd0, 12'd0},  // R1 load -> read table
        '{3'd2, 32'h0000_2000, 7'd8,  2'd0, 12'd1},  // R1 store -> write table
        '{3'd0, 32'h0000_1010, 7'd4,  2'd1, 12'd0},  // R2 read behind read
        '{3'd2, 32'h0000_2020, 7'd4,  2'd1, 12'd0},  // R2 write behind write
        '{3'd1, 32'h0000_2004, 7'd4,  2'd1, 12'd0},  // R2 read behind write
        '{3'd4, 32'h0000_1030, 7'd4,  2'd1, 12'd0},  // R2 write behind read
        '{3'd0, 32'h0000_3000, 7'd64, 2'd0, 12'd2},  // R4 exact fit
        '{3'd2, 32'h0000_3404, 7'd61, 2'd3, 12'd0},  // R4 overrun by one
        '{3'd7, 32'h0000_9000, 7'd4,  2'd3, 12'd0},  // R4 undefined kind
        '{3'd5, 32'h0000_4000, 7'd4,  2'd0, 12'd3},  // R1 locked read
        '{3'd6, 32'h0000_5000, 7'd4,  2'd0, 12'd4},  // R1 locked write
        '{3'd1, 32'h0000_6000, 7'd4,  2'd0, 12'd5},  // R1 ifetch
        '{3'd0, 32'h0000_7000, 7'd4,  2'd2, 12'd0},  // R3 at limit
        '{3'd2, 32'h0000_1000, 7'd4,  2'd1, 12'd0},  // R5 alias beats full
        '{3'd0, 32'h0000_8030, 7'd20, 2'd3, 12'd0}   // R5 malformed beats full
    };

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic goto(input int target);
        @(negedge clk);
        while (cyc < target) @(negedge clk);
    endtask

    // drive one request in the current cycle (called right after a negedge)
    task automatic send(input logic [2:0] k, input logic [31:0] a, input logic [6:0] l,
                        output logic [1:0] st, output logic [ID_W-1:0] id, output int at);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_len = l;
        #1;
        st = req_status; id = req_id; at = cyc;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic complete(input logic wr, input logic [LINE_W-1:0] ln,
                            output logic hit, output logic [ID_W-1:0] id,
                            output int lat, output logic lv, output int at);
        cpl_valid = 1'b1; cpl_wr = wr; cpl_line = ln;
        #1;
        hit = cpl_hit; id = cpl_id; lat = int'(cpl_latency); lv = cpl_lat_valid; at = cyc;
        @(posedge clk); #1;
        cpl_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [1:0]      st;
        logic [ID_W-1:0] id;
        logic            hit, lv;
        int              at, lat, acc0, a_at, b_at, c_at;

        do_reset();
        @(negedge clk);
        // R13 reset state
        check("R13 outstanding", outstanding, 0);
        check("R13 err_miss", err_miss, 0);
        check("R13 hang", hang, 0);
        check("R13 wait counters", wait_rd_on_rd + wait_wr_on_rd + wait_rd_on_wr + wait_wr_on_wr, 0);
        check("R13 next id", req_id, 0);

        // vector walk
        acc0 = 0;
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            send(VECS[v].k, VECS[v].a, VECS[v].l, st, id, at);
            check($sformatf("R5 status vec%0d", v), st, VECS[v].s);
            if (VECS[v].s == 2'd0) check($sformatf("R6 id vec%0d", v), id, VECS[v].i);
            if (v == 0) acc0 = at;
        end
        @(negedge clk);
        check("R9 outstanding after walk", outstanding, 6);
        check("R10 rd_on_rd", wait_rd_on_rd, 1);
        check("R10 wr_on_wr", wait_wr_on_wr, 1);
        check("R10 rd_on_wr", wait_rd_on_wr, 1);
        check("R10 wr_on_rd", wait_wr_on_rd, 2);

        // completions
        complete(1'b0, 26'(32'h1000 >> 6), hit, id, lat, lv, at);
        check("R7 hit load", hit, 1);
        check("R7 id load", id, 0);
        check("R7 latency", lat, at - acc0);
        check("R7 lat_valid", lv, 1);
        @(negedge clk);
        complete(1'b1, 26'(32'h4000 >> 6), hit, id, lat, lv, at);
        check("R1 locked read in write table", hit, 1);
        check("R1 locked read id", id, 3);
        @(negedge clk);
        complete(1'b0, 26'(32'h6000 >> 6), hit, id, lat, lv, at);
        check("R1 ifetch in read table", hit, 1);
        check("R1 ifetch id", id, 5);
        @(negedge clk);
        check("R9 outstanding after three completions", outstanding, 3);
        check("R8 no error yet", err_miss, 0);
        complete(1'b0, 26'(32'h5000 >> 6), hit, id, lat, lv, at);
        check("R1 locked write absent from read table", hit, 0);
        check("R8 miss lat_valid low", lv, 0);
        @(negedge clk);
        check("R8 err_miss set", err_miss, 1);
        check("R8 outstanding unchanged", outstanding, 3);
        send(3'd0, 32'h0000_1000, 7'd8, st, id, at);
        check("R7 line free again", st, 0);
        check("R6 id continues", id, 6);
        @(negedge clk);
        check("R9 outstanding after re-accept", outstanding, 4);
        check("R11 no hang with long limit", hang, 0);
        check("R8 err_miss sticky", err_miss, 1);

        // watchdog re-arm test
        do_reset();
        age_limit = 16'd10;
        @(negedge clk);
        check("R13 err_miss cleared", err_miss, 0);
        check("R13 outstanding cleared", outstanding, 0);
        send(3'd0, 32'h0000_0100, 7'd4, st, id, a_at);
        check("R13 id restarts", id, 0);
        goto(a_at + 3);
        complete(1'b0, 26'(32'h100 >> 6), hit, id, lat, lv, c_at);
        check("R7 latency three", lat, 3);
        goto(a_at + 6);
        send(3'd2, 32'h0000_0200, 7'd4, st, id, b_at);
        check("R12 second accept", st, 0);
        goto(a_at + 12);
        check("R12 no scan from stale period", hang, 0);
        goto(b_at + 10);
        check("R11 hang not before period end", hang, 0);
        goto(b_at + 11);
        check("R11 hang raised", hang, 1);
        goto(b_at + 15);
        check("R11 hang sticky", hang, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule